// File: doc/BRIEF.md
# Row-Column 8x8 Forward DCT

This block computes the two-dimensional forward discrete cosine transform of one 8x8 block of 8-bit unsigned pixels. A controller outside the block pulses a start input. The block then takes the 64 pixels in raster order through a valid/ready handshake. It transforms each row of eight pixels with an 8-point one-dimensional core and stores the eight partial results in a 64-entry transpose store. When all eight rows are stored, it reads the store back one column at a time, passes each column through the same core, and streams out 64 signed 12-bit coefficients.

The one-dimensional core uses an even/odd butterfly. Sums and differences of mirrored samples split the transform into a 4-point even half and a 4-point odd half. This halves the number of constant multiplications compared with a full 8x8 matrix product. Fixed-point cosine constants carry 15 fractional bits. Row results keep 3 guard fraction bits in the transpose store, and each pass output is rounded to nearest.

Top module: `dct8x8_rc`

## Requirements
- R1: After reset, and in idle, pix_ready_o, coef_valid_o, coef_first_o and done_o are all low. A one-cycle start_i pulse while idle begins a block, and pix_ready_o rises in the next cycle.
- R2: Pixels are 8-bit unsigned values in raster order (row 0 columns 0..7, then row 1, ...). A pixel is consumed on a rising edge where pix_valid_i and pix_ready_o are both high. Exactly 64 are taken per block, and cycles with pix_valid_i low are skipped.
- R3: Every row is transformed before any column. Row results are written to the store at address {row,column} and read back at {k,column}. No coefficient appears and no pixel is accepted from the 64th pixel until the block's last coefficient.
- R4: Each coefficient equals X(u,v) = (a(u)/2)(a(v)/2) sum over r,c of p(r,c) cos((2r+1)u*pi/16) cos((2c+1)v*pi/16) within +/-1, with a(0)=1/sqrt(2) and a(k)=1 otherwise. The value is two's complement on 12 bits; u is the vertical and v the horizontal frequency.
- R5: A block yields exactly 64 coefficients, in groups of eight consecutive valid cycles. Output n carries X(u = n mod 8, v = n div 8).
- R6: coef_first_o is high together with coefficient X(0,0) only.
- R7: done_o is a one-cycle pulse in the same cycle as the valid of the last coefficient X(7,7).
- R8: A start_i pulse while a block is in progress has no effect: the block completes unchanged and no further block begins.
- R9: A start_i pulse in the cycle where done_o is high is accepted, and pix_ready_o is high in the following cycle.
- R10: pix_valid_i held high while pix_ready_o is low, whether idle or inside a block, consumes no pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin-block pulse from the sequencing controller |
| pix_valid_i | input | 1 | Pixel on pix_i is offered |
| pix_i | input | 8 | Unsigned pixel sample |
| pix_ready_o | output | 1 | Block takes a pixel this cycle if offered |
| coef_valid_o | output | 1 | coef_o carries a coefficient |
| coef_o | output | 12 | Signed DCT coefficient |
| coef_first_o | output | 1 | Marks the DC coefficient of a block |
| done_o | output | 1 | Block finished, coincides with the last coefficient |

## Verification
Two events can fall in the same cycle: the last-coefficient completion pulse, and a new start request from the controller. The bench raises start_i in exactly the cycle where it sees done_o. It then judges that pix_ready_o is high one cycle later and that the second block's coefficients match the reference. The opposite case is also driven: a start pulse in the middle of the row phase. It is judged by an unchanged set of 64 correct coefficients and by the absence of any handshake afterwards.

// File: rtl/dct_rc_pkg.sv
package dct_rc_pkg;

  localparam int N       = 8;
  localparam int PIX_W   = 8;
  localparam int COEF_W  = 12;
  localparam int FRAC_K  = 15;
  localparam int GUARD   = 3;
  localparam int MID_W   = 14;
  localparam int ACC_W   = 40;
  localparam int IDX_W   = $clog2(N);
  localparam int ADDR_W  = 2 * IDX_W;
  localparam int ROW_SH  = FRAC_K - GUARD;
  localparam int COL_SH  = FRAC_K + GUARD;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic signed [MID_W-1:0] mid_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_IN,
    ST_ROW_WR,
    ST_COL_RD,
    ST_COL_OUT
  } phase_e;

  localparam real KSCALE = 1.0 * (64'd1 << FRAC_K);

  // half-cosines cos(k*pi/16)/2 quantised to FRAC_K fractional bits
  localparam acc_t KC1 = acc_t'($rtoi(0.4903926402 * KSCALE + 0.5));
  localparam acc_t KC2 = acc_t'($rtoi(0.4619397663 * KSCALE + 0.5));
  localparam acc_t KC3 = acc_t'($rtoi(0.4157348062 * KSCALE + 0.5));
  localparam acc_t KC4 = acc_t'($rtoi(0.3535533906 * KSCALE + 0.5));
  localparam acc_t KC5 = acc_t'($rtoi(0.2777851165 * KSCALE + 0.5));
  localparam acc_t KC6 = acc_t'($rtoi(0.1913417162 * KSCALE + 0.5));
  localparam acc_t KC7 = acc_t'($rtoi(0.0975451610 * KSCALE + 0.5));

  function automatic acc_t kmul(input acc_t v, input acc_t k);
    return v * k;
  endfunction

  // round half up, then drop the fraction chosen by the pass
  function automatic acc_t round_shr(input acc_t v, input logic col_pass);
    acc_t r;
    if (col_pass) r = (v + (acc_t'(1) <<< (COL_SH - 1))) >>> COL_SH;
    else          r = (v + (acc_t'(1) <<< (ROW_SH - 1))) >>> ROW_SH;
    return r;
  endfunction

endpackage

// File: rtl/dct_1d_core.sv
module dct_1d_core
  import dct_rc_pkg::*;
(
  input  mid_t x_i [N],
  input  logic col_pass_i,
  output mid_t y_o [N]
);

  acc_t xs [N];
  acc_t s  [N/2];
  acc_t d  [N/2];
  acc_t p  [N];
  acc_t e0, e1, e2, e3;

  for (genvar i = 0; i < N; i++) begin : g_ext
    assign xs[i] = acc_t'(x_i[i]);
  end

  for (genvar k = 0; k < N/2; k++) begin : g_bfly
    assign s[k] = xs[k] + xs[N-1-k];
    assign d[k] = xs[k] - xs[N-1-k];
  end

  // even half: second butterfly stage, then rotations
  assign e0 = s[0] + s[3];
  assign e1 = s[1] + s[2];
  assign e2 = s[0] - s[3];
  assign e3 = s[1] - s[2];

  assign p[0] = kmul(e0 + e1, KC4);
  assign p[4] = kmul(e0 - e1, KC4);
  assign p[2] = kmul(e2, KC2) + kmul(e3, KC6);
  assign p[6] = kmul(e2, KC6) - kmul(e3, KC2);

  // odd half: 4x4 product on the differences
  assign p[1] = kmul(d[0], KC1) + kmul(d[1], KC3) + kmul(d[2], KC5) + kmul(d[3], KC7);
  assign p[3] = kmul(d[0], KC3) - kmul(d[1], KC7) - kmul(d[2], KC1) - kmul(d[3], KC5);
  assign p[5] = kmul(d[0], KC5) - kmul(d[1], KC1) + kmul(d[2], KC7) + kmul(d[3], KC3);
  assign p[7] = kmul(d[0], KC7) - kmul(d[1], KC5) + kmul(d[2], KC3) - kmul(d[3], KC1);

  for (genvar i = 0; i < N; i++) begin : g_rnd
    assign y_o[i] = mid_t'(round_shr(p[i], col_pass_i));
  end

endmodule

// File: rtl/dct_tbuf.sv
module dct_tbuf
  import dct_rc_pkg::*;
#(
  parameter int DEPTH = N * N,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  mid_t          wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output mid_t          rd_data_o
);

  mid_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && rd_en_i)); // R3

endmodule

// File: rtl/dct_seq.sv
module dct_seq
  import dct_rc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  output logic             load_en_o,
  output logic             wr_en_o,
  output logic             rd_en_o,
  output logic             emit_o,
  output logic             emit_first_o,
  output logic             emit_last_o,
  output logic             col_pass_o,
  output logic [IDX_W-1:0] lane_o,
  output logic [IDX_W-1:0] line_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  phase_e           st;
  logic [IDX_W-1:0] lane, line;
  logic             lane_end, line_end;

  assign lane_end = (lane == LAST);
  assign line_end = (line == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      lane <= '0;
      line <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            st   <= ST_ROW_IN;
            lane <= '0;
            line <= '0;
          end
        end
        ST_ROW_IN: begin
          if (pix_valid_i) begin
            lane <= lane_end ? '0 : lane + 1'b1;
            if (lane_end) st <= ST_ROW_WR;
          end
        end
        ST_ROW_WR: begin
          lane <= lane_end ? '0 : lane + 1'b1;
          if (lane_end) begin
            if (line_end) begin
              st   <= ST_COL_RD;
              line <= '0;
            end else begin
              st   <= ST_ROW_IN;
              line <= line + 1'b1;
            end
          end
        end
        ST_COL_RD: begin
          lane <= lane_end ? '0 : lane + 1'b1;
          if (lane_end) st <= ST_COL_OUT;
        end
        ST_COL_OUT: begin
          lane <= lane_end ? '0 : lane + 1'b1;
          if (lane_end) begin
            if (line_end) begin
              st   <= ST_IDLE;
              line <= '0;
            end else begin
              st   <= ST_COL_RD;
              line <= line + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pix_ready_o  = (st == ST_ROW_IN);
  assign load_en_o    = pix_ready_o && pix_valid_i;
  assign wr_en_o      = (st == ST_ROW_WR);
  assign rd_en_o      = (st == ST_COL_RD);
  assign emit_o       = (st == ST_COL_OUT);
  assign col_pass_o   = emit_o;
  assign emit_first_o = emit_o && (lane == '0) && (line == '0);
  assign emit_last_o  = emit_o && lane_end && line_end;
  assign lane_o       = lane;
  assign line_o       = line;

  AST_COL_AFTER_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(wr_en_o)) |-> ($past(line) == LAST && $past(lane) == LAST)); // R3

  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !start_i) |=> !pix_ready_o); // R1

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_o && !emit_last_o) |=> (st != ST_ROW_IN)); // R8

endmodule

// File: rtl/dct8x8_rc.sv
module dct8x8_rc
  import dct_rc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic              pix_ready_o,
  output logic              coef_valid_o,
  output logic [COEF_W-1:0] coef_o,
  output logic              coef_first_o,
  output logic              done_o
);

  logic             load_en, wr_en, rd_en, emit, emit_first, emit_last, col_pass;
  logic [IDX_W-1:0] lane, line;
  mid_t             vec    [N];
  mid_t             core_y [N];
  mid_t             rd_data;
  mid_t             sel_y;
  mid_t             pix_ext;

  dct_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pix_valid_i  (pix_valid_i),
    .pix_ready_o  (pix_ready_o),
    .load_en_o    (load_en),
    .wr_en_o      (wr_en),
    .rd_en_o      (rd_en),
    .emit_o       (emit),
    .emit_first_o (emit_first),
    .emit_last_o  (emit_last),
    .col_pass_o   (col_pass),
    .lane_o       (lane),
    .line_o       (line)
  );

  assign pix_ext = mid_t'({{(MID_W-PIX_W){1'b0}}, pix_i});

  // one operand register shared by both passes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) vec[i] <= '0;
    end else if (load_en) begin
      vec[lane] <= pix_ext;
    end else if (rd_en) begin
      vec[lane] <= rd_data;
    end
  end

  dct_1d_core u_core (
    .x_i        (vec),
    .col_pass_i (col_pass),
    .y_o        (core_y)
  );

  assign sel_y = core_y[lane];

  dct_tbuf u_tbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i ({line, lane}),
    .wr_data_i (sel_y),
    .rd_en_i   (rd_en),
    .rd_addr_i ({lane, line}),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_valid_o <= 1'b0;
      coef_o       <= '0;
      coef_first_o <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      coef_valid_o <= emit;
      coef_first_o <= emit_first;
      done_o       <= emit_last;
      if (emit) coef_o <= sel_y[COEF_W-1:0];
    end
  end

  // checker state: coefficients seen in the current block
  logic [ADDR_W:0] out_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_cnt <= '0;
    else if (coef_valid_o) out_cnt <= coef_first_o ? (ADDR_W+1)'(1) : out_cnt + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (sel_y >= -mid_t'(1 << (COEF_W-1)) && sel_y < mid_t'(1 << (COEF_W-1)))); // R4

  AST_FIRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    coef_first_o |-> (coef_valid_o && !done_o)); // R6

  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (coef_valid_o && out_cnt == (ADDR_W+1)'(N*N - 1))); // R7

  AST_NO_INPUT_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    coef_valid_o |-> !pix_ready_o); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

endmodule

// File: tb/dct8x8_rc_bench.sv
module dct8x8_rc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // kind, a, b, gaps
  localparam int VEC [NV][4] = '{
    '{0, 255, 0,   0},
    '{0, 0,   0,   1},
    '{1, 10,  30,  0},
    '{2, 5,   35,  1},
    '{3, 0,   255, 0},
    '{4, 7,   0,   1},
    '{5, 3,   5,   0},
    '{4, 201, 0,   0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic [7:0]  pix_i = '0;
  logic        pix_ready_o, coef_valid_o, coef_first_o, done_o;
  logic [11:0] coef_o;

  dct8x8_rc u_dct8x8_rc (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pix_valid_i  (pix_valid_i),
    .pix_i        (pix_i),
    .pix_ready_o  (pix_ready_o),
    .coef_valid_o (coef_valid_o),
    .coef_o       (coef_o),
    .coef_first_o (coef_first_o),
    .done_o       (done_o)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  int  n_cmp = 0, n_bad = 0;
  bit  finished = 0;
  int  img [64];
  real refc [64];
  int  got [64];
  int  n_got, first_pos, done_pos;
  bit  sending;
  int  early_out;

  always @(negedge clk) begin
    if (coef_valid_o) begin
      if (sending) early_out++;
      if (n_got < 64) got[n_got] = 32'($signed(coef_o));
      if (coef_first_o) first_pos = n_got;
      if (done_o) done_pos = n_got;
      n_got++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pat_pix(input int kind, input int a, input int b,
                                 input int r, input int c);
    case (kind)
      0: return a;
      1: return a + b * c;
      2: return a + b * r;
      3: return ((r + c) % 2 == 1) ? b : a;
      4: return (a * 37 + r * 97 + c * 53 + r * c * 11 + r * c * c * 7) % 256;
      default: return (r == a && c == b) ? 255 : 0;
    endcase
  endfunction

  task automatic build(input int kind, input int a, input int b);
    real pi = 3.141592653589793;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) img[r*8+c] = pat_pix(kind, a, b, r, c);
    for (int u = 0; u < 8; u++)
      for (int v = 0; v < 8; v++) begin
        real acc = 0.0;
        real au = (u == 0) ? 0.7071067811865476 : 1.0;
        real av = (v == 0) ? 0.7071067811865476 : 1.0;
        for (int r = 0; r < 8; r++)
          for (int c = 0; c < 8; c++)
            acc += img[r*8+c] * $cos((2*r+1)*u*pi/16.0) * $cos((2*c+1)*v*pi/16.0);
        refc[u*8+v] = acc * au * av / 4.0;
      end
  endtask

  task automatic send(input int v);
    pix_valid_i = 1'b1;
    pix_i = 8'(v);
    while (!pix_ready_o) @(negedge clk);
    @(negedge clk);
  endtask

  // runs one block from the current negedge
  task automatic run_block(input int kind, input int a, input int b, input int gap,
                           input bit mid_start, input bit pre_started, input bit next_start);
    int wd = 0;
    build(kind, a, b);
    n_got = 0; first_pos = -1; done_pos = -1; early_out = 0;
    if (!pre_started) begin
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    end
    check(pix_ready_o == 1'b1, "R1", "ready after start", int'(pix_ready_o), 1);
    sending = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (gap != 0 && i % 3 == 1) begin
        pix_valid_i = 1'b0; @(negedge clk);
      end
      if (mid_start && i == 20) start_i = 1'b1;
      send(img[i]);
      start_i = 1'b0;
    end
    sending = 1'b0;
    pix_valid_i = 1'b1;   // R10: keep offering junk while not ready
    pix_i = 8'hA5;
    while (!done_o && wd < 2000) begin @(negedge clk); wd++; end
    check(wd < 2000, "R7", "done seen", wd, 0);
    if (next_start) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    pix_valid_i = 1'b0;
    check(early_out == 0, "R3", "coefficients during input phase", early_out, 0);
    check(n_got == 64, "R5", "coefficient count", n_got, 64);
    check(first_pos == 0, "R6", "first flag position", first_pos, 0);
    check(done_pos == 63, "R7", "done position", done_pos, 63);
    for (int n = 0; n < 64; n++) begin
      int ex = int'(refc[(n % 8) * 8 + n / 8]);
      int df = got[n] - ex;
      check(df <= 1 && df >= -1, "R4", $sformatf("X(%0d,%0d) order R5", n % 8, n / 8),
            got[n], ex);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_got = 0; first_pos = -1; done_pos = -1; sending = 0; early_out = 0;
    repeat (3) @(negedge clk);
    check(!pix_ready_o && !coef_valid_o && !coef_first_o && !done_o, "R1",
          "outputs in reset", int'({pix_ready_o, coef_valid_o, coef_first_o, done_o}), 0);
    rst_n = 1'b1;
    // R10: offered pixels while idle are not taken
    pix_valid_i = 1'b1; pix_i = 8'd99;
    repeat (5) begin
      @(negedge clk);
      check(pix_ready_o == 1'b0, "R10", "ready while idle", int'(pix_ready_o), 0);
    end
    pix_valid_i = 1'b0;

    for (int t = 0; t < NV; t++)
      run_block(VEC[t][0], VEC[t][1], VEC[t][2], VEC[t][3], 1'b0, 1'b0, 1'b0);

    // R8: start during the row phase is ignored
    run_block(4, 99, 0, 0, 1'b1, 1'b0, 1'b0);
    begin
      int seen = 0;
      repeat (20) begin
        @(negedge clk);
        if (pix_ready_o || coef_valid_o) seen++;
      end
      check(seen == 0, "R8", "activity after ignored start", seen, 0);
    end

    // R9: start coincides with done, second block follows at once
    run_block(1, 0, 36, 0, 1'b0, 1'b0, 1'b1);
    check(pix_ready_o == 1'b1, "R9", "ready after start on done cycle", int'(pix_ready_o), 1);
    run_block(5, 6, 1, 1, 1'b0, 1'b1, 1'b0);
    // R2: raster position confirmed by asymmetric impulse placement above

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule